// File: doc/BRIEF.md
# Parallel-Bus SAR Converter Sequencer

This block is the digital controller of a 12-bit successive-approximation converter that talks to a host over a byte-wide parallel bus. The host writes an 8-bit command with a write strobe while chip select is low. The command chooses the power state and the conversion clock source, the acquisition style, the input arrangement, the output coding and the channel. The block then tracks the input, holds it and runs thirteen conversion clock ticks. On each of the first twelve ticks it settles one result bit, most significant first, from a comparator input. When the result is ready it pulls an active-low interrupt.

The host reads the 12-bit result in two bytes, chosen by a high-byte select line. The upper byte is zero-padded for unipolar results and sign-padded for bipolar (two's complement) results. Conversion ticks come either from falling edges of an external conversion clock pin or from a clock enable made by a fixed divider of the system clock. All bus strobes are sampled on the system clock. The shared data bus is split into an input byte, an output byte and an output enable.

Top module: `sar_bus_sequencer`

## Requirements
- R1: A command is taken from `din` when `wr_n` rises while `cs_n` is low. Bits 7:6 are the power/clock code, bit 5 selects two-strobe acquisition (1) or timed acquisition (0), bit 4 selects single-ended input (1), bit 3 selects unipolar coding (1), and bits 2:0 are the channel.
- R2: Power/clock code 2'b10 selects the internal divided clock and 2'b11 selects the external conversion clock. Codes 2'b00 and 2'b01 leave the clock selection unchanged. After reset the external clock is selected, `int_n` is 1, `pwr_state` is active and `dout_oe` is 0.
- R3: With bit 5 clear, the block tracks (`track`=1) from the write. Conversion begins on the fourth conversion clock tick after the write.
- R4: A conversion lasts 13 ticks. Ticks 1 to 12 settle result bits 11 down to 0: a bit is kept when `cmp_in` is 1 while it is under trial on `sar_trial`. The result is ready on tick 13.
- R5: With bit 5 set, tracking lasts until the next write. If that write has bit 5 clear, it starts the conversion at once. If that write carries a different channel from the first write, `addr_err` is 1 from then until the next command write.
- R6: `int_n` falls when a result becomes ready. It rises on a read (`cs_n` and `rd_n` low) or on a command write, and it is low only while no acquisition or conversion is running.
- R7: A command write during an acquisition or a conversion abandons it and starts the acquisition of the new command. No result from the abandoned work is ever flagged.
- R8: While `cs_n` is 1, `wr_n`, `rd_n` and the external conversion clock have no effect, and `dout_oe` is 0.
- R9: During a read with `hben`=0, `dout` carries result bits 7:0. With `hben`=1, `dout[3:0]` carries bits 11:8 and `dout[7:4]` is 0 for a unipolar result or four copies of bit 11 for a bipolar one. A bipolar result is the settled code with bit 11 inverted.
- R10: Power code 2'b00 (shutdown, `pwr_state`=2'b10) or 2'b01 (standby, `pwr_state`=2'b01) takes effect only once the conversion it started has finished. Any later command write returns `pwr_state` to 2'b00 (active).
- R11: In internal clock mode, one tick occurs every `ICLK_DIV` system clocks and the external conversion clock is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, command taken on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte select for reads |
| conv_clk | input | 1 | External conversion clock, ticks on falling edges |
| din | input | 8 | Command byte from the bus |
| cmp_in | input | 1 | Comparator decision for the bit under trial |
| dout | output | 8 | Result byte to the bus |
| dout_oe | output | 1 | Bus output enable |
| int_n | output | 1 | Result-ready interrupt, active low |
| track | output | 1 | Track/hold control, 1 while acquiring |
| sar_trial | output | 12 | Trial code for the DAC and comparator |
| mux_chan | output | 3 | Channel of the active command |
| mux_sgl | output | 1 | Single-ended input of the active command |
| pwr_state | output | 2 | 00 active, 01 standby, 10 shutdown |
| int_clk_mode | output | 1 | 1 when the internal divided clock is selected |
| addr_err | output | 1 | Channel mismatch on two-strobe acquisition |

## Verification
The bench goes after a rewrite in the middle of a conversion. A design that failed to restart would flag a result too early, and that result would hold the old input. It checks that a power-down code keeps the clock selection and that it takes effect only after the conversion it started. A design that reverted to the external clock would stall, and one that powered down at once would change `pwr_state` early. Bipolar high-byte reads expose a missing sign fill or a missing MSB inversion, and a channel change between the two strobes must raise `addr_err`. Strobes and clock edges sent while chip select is high must leave the interrupt, the power state and the conversion progress untouched.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ACQ_INT = 2'd1,
        PH_ACQ_EXT = 2'd2,
        PH_CONV    = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE   = 2'b00,
        PWR_STANDBY  = 2'b01,
        PWR_SHUTDOWN = 2'b10
    } pwr_e;

    localparam logic [1:0] PM_SHUTDOWN = 2'b00;
    localparam logic [1:0] PM_INTCLK   = 2'b10;
    localparam logic [1:0] PM_EXTCLK   = 2'b11;

    typedef struct packed {
        logic [1:0] pmode;
        logic       ext_acq;
        logic       single;
        logic       unipolar;
        logic [2:0] chan;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] b);
        return ctrl_t'(b);
    endfunction

endpackage

// File: rtl/sarseq_tick.sv
module sarseq_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    input  logic conv_clk,
    input  logic int_mode,
    output logic wr_rise,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_cnt;
    logic          wr_q;
    logic          ext_q;
    logic          int_tick;
    logic          ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            wr_q    <= 1'b1;
            ext_q   <= 1'b0;
        end else begin
            div_cnt <= (div_cnt == CW'(DIV - 1)) ? '0 : div_cnt + 1'b1;
            wr_q    <= wr_n;
            ext_q   <= conv_clk;
        end
    end

    assign int_tick = (div_cnt == CW'(DIV - 1));
    assign ext_fall = ~cs_n & ~conv_clk & ext_q;
    assign wr_rise  = ~cs_n & wr_n & ~wr_q;
    assign tick     = int_mode ? int_tick : ext_fall;

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(div_cnt) < DIV)); // R11

endmodule

// File: rtl/sarseq_sar.sv
module sarseq_sar #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         step,
    input  logic         cmp,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            mask <= '0;
        end else if (start) begin
            code <= TOP_BIT;
            mask <= TOP_BIT;
        end else if (step) begin
            code <= (cmp ? code : (code & ~mask)) | (mask >> 1);
            mask <= mask >> 1;
        end
    end

    AST_SAR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask)); // R4

endmodule

// File: rtl/sarseq_rdmux.sv
module sarseq_rdmux #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] res,
    input  logic             res_uni,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             hben,
    output logic [BUS_W-1:0] dout,
    output logic             dout_oe
);
    localparam int HI_W  = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - HI_W;

    logic             fill;
    logic [BUS_W-1:0] hi_byte;

    assign fill = ~res_uni & res[RES_W-1];

    generate
        if (PAD_W > 0) begin : g_pad
            assign hi_byte = {{PAD_W{fill}}, res[RES_W-1:BUS_W]};
        end else begin : g_nopad
            assign hi_byte = res[RES_W-1:BUS_W];
        end
    endgenerate

    assign dout_oe = ~cs_n & ~rd_n;
    assign dout    = hben ? hi_byte : res[BUS_W-1:0];

endmodule

// File: rtl/sar_bus_sequencer.sv
module sar_bus_sequencer
    import sarseq_pkg::*;
#(
    parameter int RES_W     = 12,
    parameter int BUS_W     = 8,
    parameter int ICLK_DIV  = 4,
    parameter int ACQ_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             hben,
    input  logic             conv_clk,
    input  logic [7:0]       din,
    input  logic             cmp_in,
    output logic [BUS_W-1:0] dout,
    output logic             dout_oe,
    output logic             int_n,
    output logic             track,
    output logic [RES_W-1:0] sar_trial,
    output logic [2:0]       mux_chan,
    output logic             mux_sgl,
    output logic [1:0]       pwr_state,
    output logic             int_clk_mode,
    output logic             addr_err
);
    localparam int CNT_MAX = (RES_W > ACQ_TICKS) ? RES_W : ACQ_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [RES_W-1:0] SIGN_FLIP = {1'b1, {(RES_W-1){1'b0}}};

    phase_e           phase;
    pwr_e             pwr;
    logic [CNT_W-1:0] cnt;
    logic             clk_int;
    logic [1:0]       pd_req;
    logic [2:0]       cfg_chan;
    logic             cfg_sgl;
    logic             cfg_uni;
    logic [RES_W-1:0] res;
    logic             res_uni;
    logic             wr_rise;
    logic             tick;
    logic             rd_act;
    logic             sar_start;
    logic             sar_step;
    logic             conv_done;
    logic             acq_end;
    logic             second_wr;
    ctrl_t            nb;

    sarseq_tick #(.DIV(ICLK_DIV)) u_tick (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n),
        .conv_clk(conv_clk), .int_mode(clk_int),
        .wr_rise(wr_rise), .tick(tick)
    );

    assign nb        = decode_ctrl(din);
    assign rd_act    = ~cs_n & ~rd_n;
    assign second_wr = wr_rise && (phase == PH_ACQ_EXT) && !nb.ext_acq;
    assign acq_end   = !wr_rise && tick && (phase == PH_ACQ_INT)
                       && (cnt == CNT_W'(ACQ_TICKS - 1));
    assign sar_start = second_wr || acq_end;
    assign sar_step  = !wr_rise && tick && (phase == PH_CONV) && (cnt < CNT_W'(RES_W));
    assign conv_done = !wr_rise && tick && (phase == PH_CONV) && (cnt == CNT_W'(RES_W));

    sarseq_sar #(.W(RES_W)) u_sar (
        .clk(clk), .rst(rst), .start(sar_start), .step(sar_step),
        .cmp(cmp_in), .code(sar_trial)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            pwr      <= PWR_ACTIVE;
            cnt      <= '0;
            clk_int  <= 1'b0;
            pd_req   <= PM_EXTCLK;
            cfg_chan <= '0;
            cfg_sgl  <= 1'b1;
            cfg_uni  <= 1'b1;
            res      <= '0;
            res_uni  <= 1'b1;
            int_n    <= 1'b1;
            addr_err <= 1'b0;
        end else if (wr_rise) begin
            int_n  <= 1'b1;
            pwr    <= PWR_ACTIVE;
            pd_req <= nb.pmode;
            cnt    <= '0;
            if (nb.pmode == PM_INTCLK)      clk_int <= 1'b1;
            else if (nb.pmode == PM_EXTCLK) clk_int <= 1'b0;
            if (second_wr) begin
                phase    <= PH_CONV;
                addr_err <= (nb.chan != cfg_chan);
            end else begin
                phase    <= nb.ext_acq ? PH_ACQ_EXT : PH_ACQ_INT;
                cfg_chan <= nb.chan;
                cfg_sgl  <= nb.single;
                cfg_uni  <= nb.unipolar;
                addr_err <= 1'b0;
            end
        end else begin
            if (acq_end) begin
                phase <= PH_CONV;
                cnt   <= '0;
            end else if (conv_done) begin
                phase   <= PH_IDLE;
                res     <= cfg_uni ? sar_trial : (sar_trial ^ SIGN_FLIP);
                res_uni <= cfg_uni;
                if (pd_req == PM_SHUTDOWN)    pwr <= PWR_SHUTDOWN;
                else if (pd_req[1] == 1'b0)   pwr <= PWR_STANDBY;
            end else if (tick && (phase == PH_ACQ_INT || phase == PH_CONV)) begin
                cnt <= cnt + 1'b1;
            end
            if (conv_done)   int_n <= 1'b0;
            else if (rd_act) int_n <= 1'b1;
        end
    end

    sarseq_rdmux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_rdmux (
        .res(res), .res_uni(res_uni), .cs_n(cs_n), .rd_n(rd_n),
        .hben(hben), .dout(dout), .dout_oe(dout_oe)
    );

    assign track        = (phase == PH_ACQ_INT) || (phase == PH_ACQ_EXT);
    assign mux_chan     = cfg_chan;
    assign mux_sgl      = cfg_sgl;
    assign pwr_state    = pwr;
    assign int_clk_mode = clk_int;

    AST_WR_CLEARS_INT: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> int_n); // R6
    AST_INT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !int_n |-> (phase == PH_IDLE)); // R6
    AST_WR_WAKES: assert property (@(posedge clk) disable iff (rst)
        wr_rise |=> (pwr_state == PWR_ACTIVE)); // R10
    AST_CONV_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV) |-> (cnt <= CNT_W'(RES_W))); // R4
    AST_CS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !clk_int) |=> $stable(phase)); // R8

endmodule

// File: tb/tb_sar_bus_sequencer.sv
module tb_sar_bus_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int EXT_HALF   = 3;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
    logic        conv_clk = 1'b1;
    logic [7:0]  din = 8'h00;
    logic [11:0] analog = 12'h000;
    logic        cmp_in;
    logic [7:0]  dout;
    logic        dout_oe, int_n, track, mux_sgl, int_clk_mode, addr_err;
    logic [11:0] sar_trial;
    logic [2:0]  mux_chan;
    logic [1:0]  pwr_state;

    int n_chk = 0, n_fail = 0;
    bit finished = 0, mon_en = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign cmp_in = (analog >= sar_trial);

    sar_bus_sequencer #(.ICLK_DIV(DIV)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .hben(hben), .conv_clk(conv_clk), .din(din), .cmp_in(cmp_in),
        .dout(dout), .dout_oe(dout_oe), .int_n(int_n), .track(track),
        .sar_trial(sar_trial), .mux_chan(mux_chan), .mux_sgl(mux_sgl),
        .pwr_state(pwr_state), .int_clk_mode(int_clk_mode), .addr_err(addr_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    int ccnt = 0;
    always @(negedge clk) begin
        #1;
        ccnt++;
        if (ccnt == EXT_HALF) begin ccnt = 0; conv_clk = ~conv_clk; end
    end

    // behavioural reference model
    int m_ph, m_cnt, m_pwr, m_pdr, m_div, m_chan;
    bit m_ci, m_int, m_err, m_wrq, m_extq, m_uni, m_runi;
    logic [11:0] m_res;
    always @(posedge clk) begin
        bit wrr, tk, dn;
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_ci = 0; m_pwr = 0; m_pdr = 3; m_int = 1;
            m_err = 0; m_res = 0; m_runi = 1; m_wrq = 1; m_extq = 0; m_div = 0;
            m_uni = 1; m_chan = 0;
        end else begin
            wrr = !cs_n && wr_n && !m_wrq;
            tk  = m_ci ? (m_div == DIV-1) : (!cs_n && !conv_clk && m_extq);
            dn  = 0;
            m_wrq = wr_n; m_extq = conv_clk; m_div = (m_div + 1) % DIV;
            if (wrr) begin
                m_int = 1; m_pwr = 0; m_pdr = din[7:6]; m_cnt = 0;
                if (din[7:6] == 2) m_ci = 1; else if (din[7:6] == 3) m_ci = 0;
                if (m_ph == 2 && !din[5]) begin
                    m_ph = 3; m_err = (int'(din[2:0]) != m_chan);
                end else begin
                    m_chan = din[2:0]; m_uni = din[3]; m_err = 0;
                    m_ph = din[5] ? 2 : 1;
                end
            end else begin
                if (tk && m_ph == 1) begin
                    if (m_cnt == 3) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
                end else if (tk && m_ph == 3) begin
                    if (m_cnt == 12) begin
                        dn = 1; m_ph = 0; m_int = 0; m_runi = m_uni;
                        m_res = m_uni ? analog : (analog ^ 12'h800);
                        if (m_pdr == 0) m_pwr = 2; else if (m_pdr == 1) m_pwr = 1;
                    end else m_cnt++;
                end
                if (!dn && !cs_n && !rd_n) m_int = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en && !finished) begin
            logic [7:0] ed;
            bit eoe;
            eoe = !cs_n && !rd_n;
            ed  = hben ? {(m_runi ? 4'h0 : {4{m_res[11]}}), m_res[11:8]} : m_res[7:0];
            chk(int_n == m_int, "R6 int_n", int_n, m_int);
            chk(int'(pwr_state) == m_pwr, "R10 pwr_state", pwr_state, m_pwr);
            chk(addr_err == m_err, "R5 addr_err", addr_err, m_err);
            chk(int_clk_mode == m_ci, "R2 clock mode", int_clk_mode, m_ci);
            chk(track == (m_ph == 1 || m_ph == 2), "R3 track", track, (m_ph == 1 || m_ph == 2));
            chk(dout_oe == eoe, "R8 dout_oe", dout_oe, eoe);
            if (eoe) chk(dout == ed, "R9 dout", dout, ed);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        step(); din = b; wr_n = 1'b0;
        step(); wr_n = 1'b1;
        step();
    endtask

    task automatic rd_byte(input logic hb, output logic [7:0] v, output logic oe);
        step(); hben = hb; rd_n = 1'b0;
        @(negedge clk); v = dout; oe = dout_oe;
        #1; rd_n = 1'b1; hben = 1'b0;
    endtask

    task automatic wait_int(input int lim, output int k);
        k = 0;
        while (int_n && k < lim) begin @(negedge clk); k++; end
        chk(!int_n, "R6 completion flagged", int_n, 0);
    endtask

    task automatic read_pair(input logic [7:0] elo, input logic [7:0] ehi, input string tag);
        logic [7:0] v; logic oe;
        rd_byte(1'b0, v, oe);
        chk(oe && v == elo, {tag, " low byte"}, v, elo);
        rd_byte(1'b1, v, oe);
        chk(oe && v == ehi, {tag, " high byte"}, v, ehi);
        step();
        chk(int_n == 1'b1, "R6 read clears int_n", int_n, 1);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        chk(int_n == 1'b1, "R2 reset int_n", int_n, 1);
        chk(int_clk_mode == 1'b0, "R2 reset clock mode", int_clk_mode, 0);
        chk(pwr_state == 2'b00, "R2 reset pwr_state", pwr_state, 0);
        chk(dout_oe == 1'b0, "R2 reset dout_oe", dout_oe, 0);
        #1; rst = 1'b0; mon_en = 1;
        repeat (4) step();

        // R1 R3 R4 unipolar timed acquisition on external clock
        analog = 12'hA5C;
        wr_byte(8'hDA);
        chk(track == 1'b1 && mux_chan == 3'd2 && mux_sgl == 1'b1, "R1 R3 fields/track", {track, mux_chan}, 4'hA);
        wait_int(400, k);
        read_pair(8'h5C, 8'h0A, "R4 R9 unipolar");

        // R9 bipolar sign fill
        analog = 12'h3F3;
        wr_byte(8'hD1);
        wait_int(400, k);
        read_pair(8'hF3, 8'hFB, "R9 bipolar");

        // R11 internal clock timing
        analog = 12'h0FF;
        wr_byte(8'h98);
        chk(int_clk_mode == 1'b1, "R2 internal clock selected", int_clk_mode, 1);
        wait_int(400, k);
        chk(k >= 16*DIV && k <= 17*DIV-1, "R3 R4 R11 internal conversion length", k, 16*DIV);
        read_pair(8'hFF, 8'h00, "R4 internal");

        // R10 shutdown after conversion, clock kept
        analog = 12'h123;
        wr_byte(8'h1B);
        chk(pwr_state == 2'b00, "R10 shutdown deferred", pwr_state, 0);
        wait_int(400, k);
        @(negedge clk);
        chk(pwr_state == 2'b10, "R10 shutdown entered", pwr_state, 2);
        chk(int_clk_mode == 1'b1, "R2 clock kept by power code", int_clk_mode, 1);
        read_pair(8'h23, 8'h01, "R4 before shutdown");
        wr_byte(8'h58);
        chk(pwr_state == 2'b00, "R10 write wakes", pwr_state, 0);
        wait_int(400, k);
        @(negedge clk);
        chk(pwr_state == 2'b01, "R10 standby entered", pwr_state, 1);
        read_pair(8'h23, 8'h01, "R4 standby");
        wr_byte(8'hD8);
        chk(pwr_state == 2'b00 && int_clk_mode == 1'b0, "R10 R2 wake to external", {pwr_state, int_clk_mode}, 0);
        wait_int(400, k);
        read_pair(8'h23, 8'h01, "R4 external again");

        // R5 two-strobe acquisition
        analog = 12'h7E1;
        wr_byte(8'hFD);
        repeat (60) step();
        chk(track == 1'b1 && int_n == 1'b1, "R5 open-ended tracking", track, 1);
        wr_byte(8'hDD);
        chk(track == 1'b0, "R5 second write starts conversion", track, 0);
        wait_int(400, k);
        chk(addr_err == 1'b0, "R5 matched channel", addr_err, 0);
        read_pair(8'hE1, 8'h07, "R5 result");
        wr_byte(8'hFD);
        repeat (10) step();
        wr_byte(8'hDC);
        wait_int(400, k);
        chk(addr_err == 1'b1, "R5 channel mismatch flagged", addr_err, 1);
        step();

        // R7 abort on rewrite
        analog = 12'h555;
        wr_byte(8'hDA);
        chk(addr_err == 1'b0, "R5 flag cleared by new command", addr_err, 0);
        repeat (40) step();
        analog = 12'h2AA;
        wr_byte(8'hDA);
        wait_int(400, k);
        chk(k >= 96 && k <= 101, "R7 restart length", k, 96);
        read_pair(8'hAA, 8'h02, "R7 new result");

        // R8 chip select high
        analog = 12'h0C3;
        wr_byte(8'hDA);
        wait_int(400, k);
        step(); cs_n = 1'b1; din = 8'h1F; wr_n = 1'b0; rd_n = 1'b0;
        step(); wr_n = 1'b1;
        step(); step();
        chk(dout_oe == 1'b0, "R8 bus released", dout_oe, 0);
        chk(int_n == 1'b0, "R8 read ignored", int_n, 0);
        chk(track == 1'b0 && pwr_state == 2'b00, "R8 write ignored", {track, pwr_state}, 0);
        rd_n = 1'b1; cs_n = 1'b0;
        read_pair(8'hC3, 8'h00, "R8 result kept");
        wr_byte(8'hDA);
        cs_n = 1'b1;
        repeat (100) step();
        chk(int_n == 1'b1, "R8 conversion clock ignored", int_n, 1);
        cs_n = 1'b0;
        wait_int(300, k);
        read_pair(8'hC3, 8'h00, "R8 resumed result");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule